// File: doc/BRIEF.md
# Occupancy-Watermark Trigger Throttle

This block sits in a central trigger unit between the trigger-class decision logic and the level-0 distribution. Each of N readout nodes reports how full its multi-event buffer is. The block compares every report against a shared high mark and a shared low mark, and keeps one registered throttle flag with hysteresis. The flag sets as soon as any single node reaches the high mark. It clears only when every node has drained below the low mark.

While the flag is set, trigger requests of the selectable high-bandwidth classes are refused. The rare classes keep flowing, so that no rare event is lost to a buffer overflow. A separate hard-busy input, raised when some buffer is completely full, refuses every class. Each request produces a registered accept pulse that carries its class. Per-class saturating counters record how many requests were accepted and how many were refused.

Top module: `trig_throttle`

## Requirements
- R1: At a clock edge where at least one node's occupancy is greater than or equal to the high mark, `throttle_on` is 1 after that edge. This holds for every node index.
- R2: Once set, `throttle_on` stays 1 until a clock edge where every node's occupancy is strictly below the low mark, and it is 0 after that edge. A subset of nodes draining below the low mark does not clear it.
- R3: Class codes are 0 central, 1 minimum-bias, 2 electron and 3 muon. Bit i of the class mask marks class i as throttleable, and the mask resets to 4'b0011. A request of a masked class at an edge where `throttle_on` is 1 is refused.
- R4: When `hard_busy` is 0, a request of an unmasked class is accepted whatever the throttle state.
- R5: A request at an edge where `hard_busy` is 1 is refused, whatever its class or the mask.
- R6: A request is judged against the value `throttle_on` had before the edge that samples it. An accepted request gives `acc_valid`=1 for exactly the cycle after that edge, with `acc_class` equal to the request's class.
- R7: A threshold write (`thr_wr`) takes effect only if the new low mark is strictly less than the new high mark. Otherwise both marks keep their previous values, as seen on `thr_hi`/`thr_lo`.
- R8: For each class i, the accept and refuse counts are 16-bit fields at bits [16i+15:16i] of `acc_cnt` and `blk_cnt`. Each field counts one per request and saturates at 65535.
- R9: `cnt_clr` makes every count field 0 after the edge. It takes priority over a request counted at the same edge.
- R10: After reset, `throttle_on` and `acc_valid` are 0, all counts are 0, the marks equal their reset parameters (high 192, low 64), and the mask is 4'b0011.
- R11: The any-high and all-below-low reductions cover the node count N given as a parameter, for any N from 1 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| occ_levels | input | N*OCC_W | Buffer occupancy of node i at bits [i*OCC_W +: OCC_W] |
| hard_busy | input | 1 | Some buffer completely full; refuse all classes |
| thr_wr | input | 1 | Write strobe for both marks |
| thr_hi_in | input | OCC_W | New high mark |
| thr_lo_in | input | OCC_W | New low mark |
| mask_wr | input | 1 | Write strobe for the class mask |
| mask_in | input | 4 | New class mask, bit i = class i throttleable |
| trig_req | input | 1 | Trigger request this cycle |
| trig_class | input | 2 | Class of the request |
| cnt_clr | input | 1 | Clear all counters |
| acc_valid | output | 1 | Accept pulse, one cycle after the request |
| acc_class | output | 2 | Class of the accepted request |
| throttle_on | output | 1 | Registered throttle flag |
| thr_hi | output | OCC_W | Current high mark |
| thr_lo | output | OCC_W | Current low mark |
| acc_cnt | output | 4*CNT_W | Accepted count per class |
| blk_cnt | output | 4*CNT_W | Refused count per class |

## Verification
Two functions can fall in the same cycle. The throttle flag can change at the same edge that judges a request, and a counter clear can coincide with a counted request. The bench drives a node to the high mark in the same cycle as a central-class request and expects that request to be accepted against the old flag, with the next central request refused. It also raises `cnt_clr` alongside a request and expects all eight count fields to read zero afterwards.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int NUM_CLS = 4;
  localparam int CLS_W = 2;
  localparam logic [NUM_CLS-1:0] MASK_RST = 4'b0011;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
  import tt_pkg::*;
#(
  parameter int OCC_W  = 8,
  parameter int HI_RST = 192,
  parameter int LO_RST = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               thr_wr,
  input  logic [OCC_W-1:0]   hi_in,
  input  logic [OCC_W-1:0]   lo_in,
  input  logic               mask_wr,
  input  logic [NUM_CLS-1:0] mask_in,
  output logic [OCC_W-1:0]   hi_q,
  output logic [OCC_W-1:0]   lo_q,
  output logic [NUM_CLS-1:0] mask_q
);
  logic thr_en;
  logic [OCC_W-1:0] hi_d, lo_d;
  logic [NUM_CLS-1:0] mask_d;

  // accept a mark pair only when it keeps low strictly under high
  always_comb begin
    thr_en = thr_wr && (lo_in < hi_in);
    hi_d   = thr_en ? hi_in : hi_q;
    lo_d   = thr_en ? lo_in : lo_q;
    mask_d = mask_wr ? mask_in : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= OCC_W'(HI_RST);
      lo_q   <= OCC_W'(LO_RST);
      mask_q <= MASK_RST;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/tt_level_detect.sv
module tt_level_detect #(
  parameter int N     = 8,
  parameter int OCC_W = 8
) (
  input  logic [N*OCC_W-1:0] occ_levels,
  input  logic [OCC_W-1:0]   hi_mark,
  input  logic [OCC_W-1:0]   lo_mark,
  output logic               any_high,
  output logic               all_low
);
  logic [N-1:0] at_or_above_hi;
  logic [N-1:0] under_lo;

  for (genvar g = 0; g < N; g++) begin : g_node
    logic [OCC_W-1:0] lvl;
    assign lvl               = occ_levels[g*OCC_W +: OCC_W];
    assign at_or_above_hi[g] = (lvl >= hi_mark);
    assign under_lo[g]       = (lvl < lo_mark);
  end

  assign any_high = |at_or_above_hi;
  assign all_low  = &under_lo;
endmodule

// File: rtl/tt_gate.sv
module tt_gate
  import tt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_high,
  input  logic               all_low,
  input  logic               hard_busy,
  input  logic [NUM_CLS-1:0] mask,
  input  logic               trig_req,
  input  logic [CLS_W-1:0]   trig_class,
  output logic               throttle_q,
  output logic               acc_valid_q,
  output logic [CLS_W-1:0]   acc_class_q,
  output logic [NUM_CLS-1:0] inc_acc,
  output logic [NUM_CLS-1:0] inc_blk
);
  logic thr_d;
  logic refuse;
  logic accept;
  logic [NUM_CLS-1:0] cls_onehot;

  always_comb begin
    thr_d = throttle_q;
    if (any_high)     thr_d = 1'b1;
    else if (all_low) thr_d = 1'b0;

    refuse     = hard_busy | (mask[trig_class] & throttle_q);
    accept     = trig_req & ~refuse;
    cls_onehot = NUM_CLS'(1) << trig_class;
    inc_acc    = accept ? cls_onehot : '0;
    inc_blk    = (trig_req & refuse) ? cls_onehot : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      throttle_q  <= 1'b0;
      acc_valid_q <= 1'b0;
      acc_class_q <= '0;
    end else begin
      throttle_q  <= thr_d;
      acc_valid_q <= accept;
      if (trig_req) acc_class_q <= trig_class;
    end
  end
endmodule

// File: rtl/tt_counters.sv
module tt_counters
  import tt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [NUM_CLS-1:0]       inc_acc,
  input  logic [NUM_CLS-1:0]       inc_blk,
  output logic [NUM_CLS*CNT_W-1:0] acc_cnt,
  output logic [NUM_CLS*CNT_W-1:0] blk_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [CNT_W-1:0] a_q, a_d, b_q, b_d;

    always_comb begin
      a_d = a_q;
      b_d = b_q;
      if (clr) begin
        a_d = '0;
        b_d = '0;
      end else begin
        if (inc_acc[c] && (a_q != CNT_MAX)) a_d = a_q + 1'b1;
        if (inc_blk[c] && (b_q != CNT_MAX)) b_d = b_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
      end else begin
        a_q <= a_d;
        b_q <= b_d;
      end
    end

    assign acc_cnt[c*CNT_W +: CNT_W] = a_q;
    assign blk_cnt[c*CNT_W +: CNT_W] = b_q;
  end
endmodule

// File: rtl/trig_throttle.sv
module trig_throttle
  import tt_pkg::*;
#(
  parameter int N      = 8,
  parameter int OCC_W  = 8,
  parameter int CNT_W  = 16,
  parameter int HI_RST = 192,
  parameter int LO_RST = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N*OCC_W-1:0]       occ_levels,
  input  logic                     hard_busy,
  input  logic                     thr_wr,
  input  logic [OCC_W-1:0]         thr_hi_in,
  input  logic [OCC_W-1:0]         thr_lo_in,
  input  logic                     mask_wr,
  input  logic [NUM_CLS-1:0]       mask_in,
  input  logic                     trig_req,
  input  logic [CLS_W-1:0]         trig_class,
  input  logic                     cnt_clr,
  output logic                     acc_valid,
  output logic [CLS_W-1:0]         acc_class,
  output logic                     throttle_on,
  output logic [OCC_W-1:0]         thr_hi,
  output logic [OCC_W-1:0]         thr_lo,
  output logic [NUM_CLS*CNT_W-1:0] acc_cnt,
  output logic [NUM_CLS*CNT_W-1:0] blk_cnt
);
  // R11: supported node range
  if (N < 1 || N > 32) begin : g_bad_n
    $error("node count out of range");
  end

  logic rst_sync_n;
  logic any_high, all_low;
  logic [NUM_CLS-1:0] mask_q;
  logic [NUM_CLS-1:0] inc_acc, inc_blk;

  tt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  tt_cfg_regs #(.OCC_W(OCC_W), .HI_RST(HI_RST), .LO_RST(LO_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .thr_wr  (thr_wr),
    .hi_in   (thr_hi_in),
    .lo_in   (thr_lo_in),
    .mask_wr (mask_wr),
    .mask_in (mask_in),
    .hi_q    (thr_hi),
    .lo_q    (thr_lo),
    .mask_q  (mask_q)
  );

  tt_level_detect #(.N(N), .OCC_W(OCC_W)) u_lvl (
    .occ_levels (occ_levels),
    .hi_mark    (thr_hi),
    .lo_mark    (thr_lo),
    .any_high   (any_high),
    .all_low    (all_low)
  );

  tt_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .any_high    (any_high),
    .all_low     (all_low),
    .hard_busy   (hard_busy),
    .mask        (mask_q),
    .trig_req    (trig_req),
    .trig_class  (trig_class),
    .throttle_q  (throttle_on),
    .acc_valid_q (acc_valid),
    .acc_class_q (acc_class),
    .inc_acc     (inc_acc),
    .inc_blk     (inc_blk)
  );

  tt_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (cnt_clr),
    .inc_acc (inc_acc),
    .inc_blk (inc_blk),
    .acc_cnt (acc_cnt),
    .blk_cnt (blk_cnt)
  );
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tt_pkg::*;
#(
  parameter int OCC_W = 8,
  parameter int CNT_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     any_high,
  input logic                     all_low,
  input logic                     hard_busy,
  input logic [NUM_CLS-1:0]       mask,
  input logic                     trig_req,
  input logic [CLS_W-1:0]         trig_class,
  input logic                     cnt_clr,
  input logic                     acc_valid,
  input logic [CLS_W-1:0]         acc_class,
  input logic                     throttle_on,
  input logic [OCC_W-1:0]         thr_hi,
  input logic [OCC_W-1:0]         thr_lo,
  input logic [NUM_CLS*CNT_W-1:0] acc_cnt,
  input logic [NUM_CLS*CNT_W-1:0] blk_cnt
);
  a_r1_any_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
    any_high |=> throttle_on);

  a_r2_hold_until_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle_on && !all_low) |=> throttle_on);

  a_r2_release_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle_on && all_low && !any_high) |=> !throttle_on);

  a_r3_masked_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && throttle_on && mask[trig_class]) |=> !acc_valid);

  a_r4_unmasked_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !hard_busy && !(throttle_on && mask[trig_class]))
      |=> (acc_valid && acc_class == $past(trig_class)));

  a_r5_busy_refuses_all: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && hard_busy) |=> !acc_valid);

  a_r6_pulse_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(trig_req));

  a_r7_marks_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    thr_lo < thr_hi);

  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (acc_cnt == '0 && blk_cnt == '0));

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_sat
    a_r8_acc_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clr && acc_cnt[c*CNT_W +: CNT_W] == '1) |=> (acc_cnt[c*CNT_W +: CNT_W] == '1));
    a_r8_blk_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clr && blk_cnt[c*CNT_W +: CNT_W] == '1) |=> (blk_cnt[c*CNT_W +: CNT_W] == '1));
  end
endmodule

bind trig_throttle tt_checker #(.OCC_W(OCC_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .any_high    (any_high),
  .all_low     (all_low),
  .hard_busy   (hard_busy),
  .mask        (mask_q),
  .trig_req    (trig_req),
  .trig_class  (trig_class),
  .cnt_clr     (cnt_clr),
  .acc_valid   (acc_valid),
  .acc_class   (acc_class),
  .throttle_on (throttle_on),
  .thr_hi      (thr_hi),
  .thr_lo      (thr_lo),
  .acc_cnt     (acc_cnt),
  .blk_cnt     (blk_cnt)
);

// File: tb/trig_throttle_tb_top.sv
`timescale 1ns/1ps
module trig_throttle_tb_top;
  localparam int N = 8;
  localparam int OW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [OW-1:0] occ [N];
  logic [N*OW-1:0] occ_levels;
  logic hard_busy, thr_wr, mask_wr, trig_req, cnt_clr;
  logic [OW-1:0] thr_hi_in, thr_lo_in;
  logic [3:0] mask_in;
  logic [1:0] trig_class;
  logic acc_valid, throttle_on;
  logic [1:0] acc_class;
  logic [OW-1:0] thr_hi, thr_lo;
  logic [4*CW-1:0] acc_cnt, blk_cnt;

  int checks = 0;
  int failures = 0;
  int exp_acc [4];
  int exp_blk [4];
  logic [3:0] cur_mask;
  logic cur_thr;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) occ_levels[i*OW +: OW] = occ[i];
  end

  trig_throttle dut_i (
    .clk(clk), .rst_n(rst_n), .occ_levels(occ_levels), .hard_busy(hard_busy),
    .thr_wr(thr_wr), .thr_hi_in(thr_hi_in), .thr_lo_in(thr_lo_in),
    .mask_wr(mask_wr), .mask_in(mask_in), .trig_req(trig_req),
    .trig_class(trig_class), .cnt_clr(cnt_clr), .acc_valid(acc_valid),
    .acc_class(acc_class), .throttle_on(throttle_on), .thr_hi(thr_hi),
    .thr_lo(thr_lo), .acc_cnt(acc_cnt), .blk_cnt(blk_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_all(input int v);
    for (int i = 0; i < N; i++) occ[i] = OW'(v);
  endtask

  task automatic check_counts(input string req);
    for (int c = 0; c < 4; c++) begin
      check({req, " acc count"}, int'(acc_cnt[c*CW +: CW]), exp_acc[c]);
      check({req, " blk count"}, int'(blk_cnt[c*CW +: CW]), exp_blk[c]);
    end
  endtask

  // one request; expectation from R3/R4/R5
  task automatic fire(input int c, input string req);
    bit exp_ok;
    exp_ok = !hard_busy && !(cur_thr && cur_mask[c]);
    trig_req = 1'b1;
    trig_class = 2'(c);
    step();
    trig_req = 1'b0;
    check({req, " accept"}, int'(acc_valid), int'(exp_ok));
    if (exp_ok) begin
      check({req, " class"}, int'(acc_class), c);
      if (exp_acc[c] < 65535) exp_acc[c]++;
    end else if (exp_blk[c] < 65535) exp_blk[c]++;
    step();
    check("R6 pulse one cycle", int'(acc_valid), 0);
  endtask

  task automatic write_thr(input int hi, input int lo);
    thr_hi_in = OW'(hi);
    thr_lo_in = OW'(lo);
    thr_wr = 1'b1;
    step();
    thr_wr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_all(0);
    hard_busy = 0; thr_wr = 0; mask_wr = 0; trig_req = 0; cnt_clr = 0;
    thr_hi_in = '0; thr_lo_in = '0; mask_in = '0; trig_class = '0;
    for (int c = 0; c < 4; c++) begin exp_acc[c] = 0; exp_blk[c] = 0; end
    cur_mask = 4'b0011;
    cur_thr = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R10 reset state
    check("R10 throttle", int'(throttle_on), 0);
    check("R10 acc_valid", int'(acc_valid), 0);
    check("R10 hi mark", int'(thr_hi), 192);
    check("R10 lo mark", int'(thr_lo), 64);
    check_counts("R10");

    // R7 threshold writes
    write_thr(100, 40);
    check("R7 hi applied", int'(thr_hi), 100);
    check("R7 lo applied", int'(thr_lo), 40);
    write_thr(90, 90);
    check("R7 equal hi kept", int'(thr_hi), 100);
    check("R7 equal lo kept", int'(thr_lo), 40);
    write_thr(50, 120);
    check("R7 inverted hi kept", int'(thr_hi), 100);
    check("R7 inverted lo kept", int'(thr_lo), 40);

    // R1/R11 every node index, just below and at the high mark
    for (int i = 0; i < N; i++) begin
      occ[i] = OW'(99);
      step();
      check("R1 below high no throttle", int'(throttle_on), 0);
      occ[i] = OW'(100);
      step();
      check("R1 R11 node at high sets", int'(throttle_on), 1);
      occ[i] = OW'(0);
      step();
      check("R2 all drained releases", int'(throttle_on), 0);
    end

    // R2 partial drain keeps throttle
    occ[2] = OW'(255);
    step();
    check("R1 full level sets", int'(throttle_on), 1);
    occ[2] = OW'(0);
    occ[5] = OW'(40);
    step();
    check("R2 one node at low holds", int'(throttle_on), 1);
    occ[5] = OW'(70);
    step();
    check("R2 node between marks holds", int'(throttle_on), 1);
    occ[5] = OW'(39);
    step();
    check("R2 all below low releases", int'(throttle_on), 0);

    // R3 R4 R5 sweep over throttle, busy and class with reset mask
    for (int t = 0; t < 2; t++) begin
      occ[0] = (t == 1) ? OW'(100) : OW'(0);
      step();
      cur_thr = (t == 1);
      check("R1 sweep throttle state", int'(throttle_on), t);
      for (int hb = 0; hb < 2; hb++) begin
        hard_busy = (hb == 1);
        for (int c = 0; c < 4; c++) fire(c, "R3 R4 R5 sweep");
      end
      hard_busy = 1'b0;
    end
    check_counts("R8 after sweep");

    // R3 rewritten mask under throttle: only electron throttleable
    mask_in = 4'b0100;
    mask_wr = 1'b1;
    step();
    mask_wr = 1'b0;
    cur_mask = 4'b0100;
    for (int c = 0; c < 4; c++) fire(c, "R3 R4 new mask");

    // R6 crossing in same cycle as request: judged against old flag
    occ[0] = OW'(0);
    step();
    cur_thr = 1'b0;
    check("R2 release before crossing", int'(throttle_on), 0);
    mask_in = 4'b0011;
    mask_wr = 1'b1;
    step();
    mask_wr = 1'b0;
    cur_mask = 4'b0011;
    occ[3] = OW'(100);
    fire(0, "R6 same-cycle crossing old flag");
    cur_thr = 1'b1;
    check("R1 flag after crossing", int'(throttle_on), 1);
    fire(0, "R3 after crossing refused");
    check_counts("R8 before clear");

    // R9 clear coinciding with a request
    occ[3] = OW'(0);
    cnt_clr = 1'b1;
    trig_req = 1'b1;
    trig_class = 2'd2;
    step();
    cnt_clr = 1'b0;
    trig_req = 1'b0;
    cur_thr = 1'b0;
    for (int c = 0; c < 4; c++) begin exp_acc[c] = 0; exp_blk[c] = 0; end
    check_counts("R9 clear wins");

    // R8 saturation of the muon accept count
    trig_class = 2'd3;
    trig_req = 1'b1;
    repeat (65540) @(posedge clk);
    #1;
    trig_req = 1'b0;
    step();
    exp_acc[3] = 65535;
    check_counts("R8 saturation");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule